// File: doc/BRIEF.md
# Upper-Triangular Matrix Inverse Engine

This block inverts an N×N upper-triangular matrix held in fixed point by back-substitution. It is the second stage of a QR-based inverse: the factorization stage hands it the triangular factor, and a later stage multiplies the result by the transposed orthogonal factor. Matrix elements are 16-bit signed integers. They arrive one per accepted handshake on a write port and fill internal storage in row-major order.

A start pulse launches the run. The engine works from the bottom row to the top row. For each row it first forms the reciprocal of the diagonal element with a sequential divider. It then builds each entry to the right of the diagonal with a single multiply-accumulate datapath: a negated sum of products with rows that are already finished, scaled by that reciprocal. Results use a 32-bit signed format with 15 fractional bits. Once done is high they can be read back one element per cycle through an addressed read port.

Top module: `tri_inv_engine`

## Requirements
- R1: wr_ready is high exactly while the engine is idle. Each accepted wr_data word goes to the next row-major slot (slot index = row·N + column), starting at slot 0 after reset and after every start. Words offered while busy are not accepted and do not change the matrix used by the next run.
- R2: start while idle raises busy on the next cycle and clears done. When the run ends, busy falls and done rises. done then stays high until the next start. busy and done are never high together.
- R3: Each diagonal result Rinv(r,r) equals sign(R(r,r))·floor(2^15/|R(r,r)|), as a 32-bit two's-complement value with 15 fractional bits (1.0 = 32768).
- R4: Each entry with column c greater than row r equals floor(A·Rinv(r,r)/2^15), saturated to 32 bits. Here A = −Σ R(r,t)·Rinv(t,c) for t from r+1 to c, with A kept exactly.
- R5: Rows of the result are produced from row N−1 down to row 0, and no row is written after a row above it.
- R6: Every result entry below the diagonal reads as zero, and input elements below the diagonal have no effect on any result.
- R7: A zero diagonal element yields the reciprocal 0x7FFFFFFF and sets singular. The run still completes with done. singular stays high until the next start clears it.
- R8: When the scaled value falls outside the 32-bit signed range, the result is 0x7FFFFFFF (above) or 0x80000000 (below).
- R9: rd_data presents the result entry at slot rd_addr (row·N + column) one clock after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Engine accepts a write word (idle) |
| wr_data | input | 16 | Signed matrix element |
| start | input | 1 | Begin inversion (idle only) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result ready; held until next start |
| singular | output | 1 | Zero diagonal seen during last run |
| rd_addr | input | clog2(N·N) | Row-major result slot to read |
| rd_data | output | 32 | Result element, 15 fractional bits |

## Verification
The assertions check on every cycle that busy and done are exclusive, that start raises busy and that done and singular hold between runs. They also check that result rows are written bottom-up, that nothing is written below the diagonal, and that every reciprocal stays within ±1.0·2^15. Only the bench's scenarios can show the numeric results. These are the exact diagonal reciprocals, the negated accumulations with floor rounding, saturation at both limits of the output range, and the value substituted for a zero diagonal. The scenarios also show that lower-triangle inputs and writes offered while busy leave the results unchanged.

// File: rtl/tri_inv_pkg.sv
package tri_inv_pkg;

    localparam int IN_W  = 16;
    localparam int OUT_W = 32;
    localparam int FRAC  = 15;

    typedef logic signed [IN_W-1:0]  elem_t;
    typedef logic signed [OUT_W-1:0] inv_t;

    localparam inv_t INV_MAX = {1'b0, {(OUT_W-1){1'b1}}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_ACC,
        ST_SCALE
    } state_t;

    typedef struct packed {
        elem_t r_elem;
        inv_t  inv_elem;
        logic  clr;
    } mac_op_t;

endpackage

// File: rtl/tri_recip_div.sv
module tri_recip_div
    import tri_inv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  elem_t den,
    output logic  done_o,
    output logic  zero_o,
    output inv_t  q_o
);
    localparam int QW = FRAC + 1;
    localparam int CW = $clog2(QW + 1);

    logic            running;
    logic [CW-1:0]   cnt;
    logic [IN_W:0]   mag;
    logic [IN_W:0]   rem;
    logic [QW-1:0]   dvd;
    logic [QW-1:0]   quo;
    logic            neg;

    logic [IN_W:0]   den_ext;
    logic [IN_W:0]   den_mag;
    logic [IN_W+1:0] trial;
    logic            fits;
    logic [QW-1:0]   quo_n;
    inv_t            q_ext;

    always_comb begin
        den_ext = {den[IN_W-1], den};
        den_mag = den[IN_W-1] ? (~den_ext + 1'b1) : den_ext;
        trial   = {rem, dvd[QW-1]};
        fits    = trial >= {1'b0, mag};
        quo_n   = {quo[QW-2:0], fits};
        q_ext   = inv_t'({{(OUT_W-QW){1'b0}}, quo_n});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            mag     <= '0;
            rem     <= '0;
            dvd     <= '0;
            quo     <= '0;
            neg     <= 1'b0;
            done_o  <= 1'b0;
            zero_o  <= 1'b0;
            q_o     <= '0;
        end else begin
            done_o <= 1'b0;
            if (go && !running) begin
                if (den == '0) begin
                    done_o <= 1'b1;
                    zero_o <= 1'b1;
                    q_o    <= INV_MAX;
                end else begin
                    running <= 1'b1;
                    zero_o  <= 1'b0;
                    cnt     <= '0;
                    mag     <= den_mag;
                    rem     <= '0;
                    dvd     <= QW'(1) << FRAC;
                    quo     <= '0;
                    neg     <= den[IN_W-1];
                end
            end else if (running) begin
                rem <= fits ? (IN_W+1)'(trial - {1'b0, mag}) : trial[IN_W:0];
                dvd <= dvd << 1;
                quo <= quo_n;
                cnt <= cnt + 1'b1;
                if (cnt == CW'(QW - 1)) begin
                    running <= 1'b0;
                    done_o  <= 1'b1;
                    q_o     <= neg ? (~q_ext + 1'b1) : q_ext;
                end
            end
        end
    end

    localparam inv_t Q_LIM = inv_t'(1) <<< FRAC;

    a_r3_recip_range: assert property (@(posedge clk) disable iff (rst)
        (done_o && !zero_o) |-> (q_o <= Q_LIM && q_o >= -Q_LIM));

endmodule

// File: rtl/tri_mac.sv
module tri_mac
    import tri_inv_pkg::*;
#(
    parameter int ACC_W = 51
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  mac_op_t op,
    input  inv_t    recip,
    output inv_t    y
);
    localparam int PROD_W = IN_W + OUT_W;
    localparam int SCL_W  = ACC_W + OUT_W;
    localparam logic signed [SCL_W-1:0] HI = {{(SCL_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [SCL_W-1:0] LO = {{(SCL_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [ACC_W-1:0]  acc;
    logic signed [PROD_W-1:0] prod;
    logic signed [SCL_W-1:0]  scaled;
    logic signed [SCL_W-1:0]  shifted;

    always_comb begin
        prod    = PROD_W'(op.r_elem) * PROD_W'(op.inv_elem);
        scaled  = SCL_W'(acc) * SCL_W'(recip);
        shifted = scaled >>> FRAC;
        if (shifted > HI)
            y = INV_MAX;
        else if (shifted < LO)
            y = ~INV_MAX;
        else
            y = shifted[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= (op.clr ? '0 : acc) - ACC_W'(prod);
    end

endmodule

// File: rtl/tri_inv_engine.sv
module tri_inv_engine
    import tri_inv_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_valid,
    output logic                      wr_ready,
    input  logic [IN_W-1:0]           wr_data,
    input  logic                      start,
    output logic                      busy,
    output logic                      done,
    output logic                      singular,
    input  logic [$clog2(N*N)-1:0]    rd_addr,
    output logic [OUT_W-1:0]          rd_data
);
    localparam int CELLS = N * N;
    localparam int AW    = $clog2(CELLS);
    localparam int IW    = $clog2(N);
    localparam int ACC_W = IN_W + OUT_W + $clog2(N) + 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    function automatic logic [AW-1:0] slot(input logic [IW-1:0] r, input logic [IW-1:0] c);
        return AW'(r) * AW'(N) + AW'(c);
    endfunction

    state_t        state;
    logic [IW-1:0] row, col, t;
    logic [AW-1:0] wptr;
    inv_t          recip;
    elem_t         rmem [CELLS];
    inv_t          imem [CELLS];

    logic          div_go, div_done, div_zero;
    inv_t          div_q;
    mac_op_t       mop;
    logic          mac_en;
    inv_t          mac_y;

    logic          iw_en;
    logic [IW-1:0] iw_row, iw_col;
    inv_t          iw_data;
    logic          launch;

    assign busy     = (state != ST_IDLE);
    assign wr_ready = (state == ST_IDLE);
    assign launch   = start && (state == ST_IDLE);
    assign div_go   = (state == ST_DIV_GO);
    assign mac_en   = (state == ST_ACC);

    always_comb begin
        mop.r_elem   = rmem[slot(row, t)];
        mop.inv_elem = imem[slot(t, col)];
        mop.clr      = (t == row + IW'(1));
        iw_en        = (state == ST_DIV_WAIT && div_done) || (state == ST_SCALE);
        iw_row       = row;
        iw_col       = (state == ST_SCALE) ? col : row;
        iw_data      = (state == ST_SCALE) ? mac_y : div_q;
    end

    tri_recip_div u_div (
        .clk    (clk),
        .rst    (rst),
        .go     (div_go),
        .den    (rmem[slot(row, row)]),
        .done_o (div_done),
        .zero_o (div_zero),
        .q_o    (div_q)
    );

    tri_mac #(.ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst   (rst),
        .en    (mac_en),
        .op    (mop),
        .recip (recip),
        .y     (mac_y)
    );

    // write port into the input matrix store
    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            for (int i = 0; i < CELLS; i++) rmem[i] <= '0;
        end else if (state == ST_IDLE) begin
            if (wr_valid) begin
                rmem[wptr] <= elem_t'(wr_data);
                wptr       <= (wptr == AW'(CELLS - 1)) ? '0 : wptr + 1'b1;
            end
            if (start) wptr <= '0;
        end
    end

    // sequencer and result store
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            row      <= '0;
            col      <= '0;
            t        <= '0;
            recip    <= '0;
            done     <= 1'b0;
            singular <= 1'b0;
            rd_data  <= '0;
            for (int i = 0; i < CELLS; i++) imem[i] <= '0;
        end else begin
            rd_data <= imem[rd_addr];
            if (iw_en) imem[slot(iw_row, iw_col)] <= iw_data;
            unique case (state)
                ST_IDLE: if (start) begin
                    for (int i = 0; i < CELLS; i++) imem[i] <= '0;
                    row      <= LAST;
                    done     <= 1'b0;
                    singular <= 1'b0;
                    state    <= ST_DIV_GO;
                end
                ST_DIV_GO: state <= ST_DIV_WAIT;
                ST_DIV_WAIT: if (div_done) begin
                    recip <= div_q;
                    if (div_zero) singular <= 1'b1;
                    if (row == LAST) begin
                        row   <= row - IW'(1);
                        state <= ST_DIV_GO;
                    end else begin
                        col   <= row + IW'(1);
                        t     <= row + IW'(1);
                        state <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (t == col) state <= ST_SCALE;
                    else          t     <= t + IW'(1);
                end
                ST_SCALE: begin
                    if (col == LAST) begin
                        if (row == '0) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            row   <= row - IW'(1);
                            state <= ST_DIV_GO;
                        end
                    end else begin
                        col   <= col + IW'(1);
                        t     <= row + IW'(1);
                        state <= ST_ACC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // checker state: lowest row written so far in this run
    logic [IW-1:0] low_row;
    always_ff @(posedge clk) begin
        if (rst || launch) low_row <= LAST;
        else if (iw_en)    low_row <= iw_row;
    end

    a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        launch |=> (busy && !done));
    a_r2_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    a_r7_singular_sticky: assert property (@(posedge clk) disable iff (rst)
        (singular && !launch) |=> singular);
    a_r5_row_order: assert property (@(posedge clk) disable iff (rst)
        iw_en |-> (iw_row <= low_row));
    a_r6_upper_only: assert property (@(posedge clk) disable iff (rst)
        iw_en |-> (iw_col >= iw_row));

endmodule

// File: tb/tri_inv_engine_bench.sv
module tri_inv_engine_bench;
    localparam int N     = 4;
    localparam int CELLS = N * N;
    localparam int AW    = $clog2(CELLS);

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_valid;
    logic             wr_ready;
    logic [15:0]      wr_data;
    logic             start;
    logic             busy, done, singular;
    logic [AW-1:0]    rd_addr;
    logic [31:0]      rd_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic signed [15:0] bm [CELLS];
    logic signed [31:0] ex [CELLS];

    always #10 clk = ~clk;

    tri_inv_engine #(.N(N)) u_tri_inv_engine (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .start(start), .busy(busy), .done(done),
        .singular(singular), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference back-substitution from the requirements
    task automatic model();
        logic signed [127:0] hi, lo, d, q, acc, a, b, s;
        hi = 128'sh7fffffff;
        lo = -128'sh80000000;
        for (int i = 0; i < CELLS; i++) ex[i] = '0;
        for (int r = N - 1; r >= 0; r--) begin
            d = bm[r*N+r];
            if (d == 0) q = hi;
            else begin
                q = 128'sd32768 / (d < 0 ? -d : d);
                if (d < 0) q = -q;
            end
            ex[r*N+r] = q[31:0];
            for (int c = r + 1; c < N; c++) begin
                acc = '0;
                for (int k = r + 1; k <= c; k++) begin
                    a = bm[r*N+k];
                    b = ex[k*N+c];
                    acc = acc - a * b;
                end
                s = (acc * q) >>> 15;
                if (s > hi) s = hi;
                if (s < lo) s = lo;
                ex[r*N+c] = s[31:0];
            end
        end
    endtask

    task automatic load();
        for (int i = 0; i < CELLS; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = bm[i];
            chk("R1 wr_ready idle", {31'b0, wr_ready}, 32'd1);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic run(input logic junk_writes);
        int n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", {31'b0, busy}, 32'd1);
        chk("R2 done cleared", {31'b0, done}, 32'd0);
        chk("R1 not ready while busy", {31'b0, wr_ready}, 32'd0);
        if (junk_writes) begin
            wr_valid = 1'b1;
            wr_data  = 16'h5a5a;
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        wr_valid = 1'b0;
        chk("R2 done at end", {31'b0, done}, 32'd1);
        chk("R2 busy low at end", {31'b0, busy}, 32'd0);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < CELLS; i++) begin
            @(negedge clk);
            rd_addr = AW'(i);
            @(negedge clk);
            chk(tag, rd_data, ex[i]);
        end
    endtask

    task automatic t_reset();
        chk("R2 reset busy", {31'b0, busy}, 32'd0);
        chk("R2 reset done", {31'b0, done}, 32'd0);
        chk("R7 reset singular", {31'b0, singular}, 32'd0);
        chk("R1 reset ready", {31'b0, wr_ready}, 32'd1);
    endtask

    task automatic t_diag();
        for (int i = 0; i < CELLS; i++) bm[i] = '0;
        bm[0] = 16'sd3; bm[5] = -16'sd7; bm[10] = 16'sd1; bm[15] = -16'sd32768;
        model();
        load();
        run(1'b0);
        read_all("R3 R9 diagonal reciprocal");
        chk("R3 recip of 3", ex[0], 32'd10922);
        chk("R3 recip of -32768", ex[15], 32'hffffffff);
    endtask

    task automatic t_general(input logic signed [15:0] junk);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                bm[r*N+c] = (c < r) ? junk + 16'(r*7+c) :
                            (c == r) ? 16'(r + 2) : 16'(5 - 3*c + r);
        model();
        load();
        run(1'b0);
        read_all("R4 R6 general entries");
        chk("R7 singular clear on good run", {31'b0, singular}, 32'd0);
    endtask

    task automatic t_busy_writes();
        run(1'b1);
        read_all("R1 busy writes ignored");
    endtask

    task automatic t_singular();
        for (int i = 0; i < CELLS; i++) bm[i] = (i % N >= i / N) ? 16'sd2 : 16'sd0;
        bm[2*N+2] = 16'sd0;
        model();
        load();
        run(1'b0);
        chk("R7 singular set", {31'b0, singular}, 32'd1);
        read_all("R7 singular entries");
        chk("R7 zero diag recip", ex[2*N+2], 32'h7fffffff);
        repeat (5) @(negedge clk);
        chk("R7 singular sticky", {31'b0, singular}, 32'd1);
        chk("R2 done held", {31'b0, done}, 32'd1);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < CELLS; i++)
            bm[i] = (i % N > i / N) ? -16'sd32768 : ((i % N == i / N) ? 16'sd1 : 16'sd0);
        model();
        load();
        run(1'b0);
        read_all("R8 saturated entries");
        chk("R8 model saturates", ex[1*N+3], 32'h7fffffff);
        bm[0] = -16'sd1;
        model();
        load();
        run(1'b0);
        read_all("R8 negative saturation entries");
    endtask

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_data = '0; start = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_diag();
        t_general(16'sh1234);
        t_general(-16'sd999);
        t_busy_writes();
        t_singular();
        t_general(16'sh0abc);
        t_saturate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule